// File: doc/BRIEF.md
# Deflecting Torus Router

A single node of a one-way two-dimensional torus network. Each cycle it takes up to three messages: one arriving on the horizontal ring, one arriving on the vertical ring and one offered by the local client. It places them on two registered outputs, the horizontal ring output and the vertical ring output. The router stores nothing and keeps no credit counters or channel state. A message that cannot have the output it wants is not held back. It is sent on along the ring it is already travelling and comes back to this router later.

Routing is dimension ordered. A message moves horizontally until its destination column equals this router's column, then turns onto the vertical ring. The local client receives by watching the vertical output. When the message placed there is addressed to this router, a delivery flag is raised and the message's valid bit is cleared, so the next router does not take it again. The client may inject only into an output that ring traffic leaves free. A combinational ready tells it in the same cycle whether its message was taken. The coordinate widths, the payload width and the router's own coordinates are parameters.

Top module: `tor_router`

## Requirements
- R1: While rst_ni is low, x_o, y_o and dlv_o are all zero and no message is forwarded.
- R2: A message is MSG_W = 1+X_W+Y_W+PAY_W bits: bit MSG_W-1 is valid, the next X_W bits below it are the destination column, the next Y_W bits are the destination row, and the low PAY_W bits are payload. The router never alters destination or payload bits.
- R3: A valid vertical-ring input always leaves on y_o in the next cycle.
- R4: A valid horizontal-ring input whose destination column differs from MY_X leaves on x_o in the next cycle.
- R5: A valid horizontal-ring input whose destination column equals MY_X leaves on y_o in the next cycle when no vertical-ring input is valid in the same cycle.
- R6: A horizontal-ring input that would turn while a vertical-ring input is valid is deflected onto x_o unchanged in the next cycle.
- R7: When the message routed to y_o has destination column MY_X and row MY_Y, dlv_o is 1 and y_o carries its fields with the valid bit cleared in the next cycle. Otherwise dlv_o is 0.
- R8: A client message needs y_o if its destination column equals MY_X and x_o otherwise. c_ready_o is 1 only when the client message is valid and the output it needs is not claimed by ring traffic in that cycle. An accepted message appears on that output in the next cycle.
- R9: An output that receives no message in a cycle is all zero in the next cycle. Inputs whose valid bit is 0 have no effect.
- R10: Nothing is lost or duplicated. The number of valid ring inputs plus accepted client messages in a cycle equals the number of set bits among x_o valid, y_o valid and dlv_o in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_i | input | MSG_W | Message arriving on the horizontal ring |
| y_i | input | MSG_W | Message arriving on the vertical ring |
| c_i | input | MSG_W | Message offered by the local client |
| c_ready_o | output | 1 | Client message accepted this cycle |
| x_o | output | MSG_W | Registered horizontal ring output |
| y_o | output | MSG_W | Registered vertical ring output, also read by the client |
| dlv_o | output | 1 | y_o holds a message delivered to this router |

## Verification
A wrong select or a bad accept decision shows on the ports one cycle later. A message is then missing from both outputs, appears twice, lands on the wrong ring, or is delivered with its valid bit still set. Because nothing is stored, any fault shows within one hop and never stays hidden in internal state. The bench compares every output and the ready bit against an independent behavioural model on every cycle. It runs directed contention cases and then long stretches of random traffic, so that each such slip is seen in the cycle it happens.

// File: rtl/tor_pkg.sv
package tor_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_X    = 2'd1,
    SEL_Y    = 2'd2,
    SEL_C    = 2'd3
  } sel_e;

  localparam int unsigned N_IN  = 3;
  localparam int unsigned N_OUT = 2;
  localparam int unsigned IN_X  = 0;
  localparam int unsigned IN_Y  = 1;
  localparam int unsigned IN_C  = 2;
endpackage

// File: rtl/tor_hdr_dec.sv
module tor_hdr_dec #(
  parameter int unsigned X_W  = 2,
  parameter int unsigned Y_W  = 2,
  parameter int unsigned MY_X = 0,
  parameter int unsigned MY_Y = 0,
  localparam int unsigned HDR_W = 1 + X_W + Y_W
) (
  input  logic [HDR_W-1:0] hdr_i,
  output logic             vld_o,
  output logic             col_hit_o,
  output logic             here_o
);
  logic [X_W-1:0] dst_x;
  logic [Y_W-1:0] dst_y;

  assign vld_o     = hdr_i[HDR_W-1];
  assign dst_x     = hdr_i[HDR_W-2 -: X_W];
  assign dst_y     = hdr_i[Y_W-1:0];
  assign col_hit_o = (dst_x == X_W'(MY_X));
  assign here_o    = col_hit_o && (dst_y == Y_W'(MY_Y));
endmodule

// File: rtl/tor_arb.sv
module tor_arb
  import tor_pkg::*;
(
  input  logic x_vld_i,
  input  logic x_col_i,
  input  logic y_vld_i,
  input  logic c_vld_i,
  input  logic c_col_i,
  output sel_e sel_x_o,
  output sel_e sel_y_o,
  output logic c_acc_o
);
  logic x_turn, x_stay, y_busy, x_busy;

  // vertical ring owns y_o; a blocked turn deflects onto x_o
  assign x_turn  = x_vld_i && x_col_i && !y_vld_i;
  assign x_stay  = x_vld_i && !x_turn;
  assign y_busy  = y_vld_i || x_turn;
  assign x_busy  = x_stay;
  assign c_acc_o = c_vld_i && (c_col_i ? !y_busy : !x_busy);

  always_comb begin
    sel_x_o = SEL_NONE;
    sel_y_o = SEL_NONE;
    if (x_stay)                  sel_x_o = SEL_X;
    else if (c_acc_o && !c_col_i) sel_x_o = SEL_C;
    if (y_vld_i)                 sel_y_o = SEL_Y;
    else if (x_turn)             sel_y_o = SEL_X;
    else if (c_acc_o && c_col_i) sel_y_o = SEL_C;
  end
endmodule

// File: rtl/tor_out_stage.sv
module tor_out_stage
  import tor_pkg::*;
#(
  parameter int unsigned MSG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  sel_e             sel_i,
  input  logic             dlv_i,
  input  logic [MSG_W-1:0] x_msg_i,
  input  logic [MSG_W-1:0] y_msg_i,
  input  logic [MSG_W-1:0] c_msg_i,
  output logic [MSG_W-1:0] q_o,
  output logic             dlv_o
);
  logic [MSG_W-1:0] pick, nxt;

  always_comb begin
    unique case (sel_i)
      SEL_X:   pick = x_msg_i;
      SEL_Y:   pick = y_msg_i;
      SEL_C:   pick = c_msg_i;
      default: pick = '0;
    endcase
    nxt = pick;
    // delivered message must not be taken again downstream
    if (dlv_i) nxt[MSG_W-1] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o   <= '0;
      dlv_o <= 1'b0;
    end else begin
      q_o   <= nxt;
      dlv_o <= dlv_i;
    end
  end
endmodule

// File: rtl/tor_router.sv
module tor_router
  import tor_pkg::*;
#(
  parameter int unsigned X_W   = 2,
  parameter int unsigned Y_W   = 2,
  parameter int unsigned PAY_W = 8,
  parameter int unsigned MY_X  = 1,
  parameter int unsigned MY_Y  = 2,
  localparam int unsigned HDR_W = 1 + X_W + Y_W,
  localparam int unsigned MSG_W = HDR_W + PAY_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [MSG_W-1:0] x_i,
  input  logic [MSG_W-1:0] y_i,
  input  logic [MSG_W-1:0] c_i,
  output logic             c_ready_o,
  output logic [MSG_W-1:0] x_o,
  output logic [MSG_W-1:0] y_o,
  output logic             dlv_o
);
  logic [MSG_W-1:0] in_msg [N_IN];
  logic [N_IN-1:0]  vld, col, here;
  sel_e             sel [N_OUT];
  logic [N_OUT-1:0] dlv_sel;
  logic [MSG_W-1:0] q   [N_OUT];
  logic [N_OUT-1:0] dlv_q;
  logic             y_here;

  assign in_msg[IN_X] = x_i;
  assign in_msg[IN_Y] = y_i;
  assign in_msg[IN_C] = c_i;

  for (genvar i = 0; i < N_IN; i++) begin : g_dec
    tor_hdr_dec #(
      .X_W (X_W),
      .Y_W (Y_W),
      .MY_X(MY_X),
      .MY_Y(MY_Y)
    ) u_dec (
      .hdr_i    (in_msg[i][MSG_W-1:PAY_W]),
      .vld_o    (vld[i]),
      .col_hit_o(col[i]),
      .here_o   (here[i])
    );
  end

  tor_arb u_arb (
    .x_vld_i(vld[IN_X]),
    .x_col_i(col[IN_X]),
    .y_vld_i(vld[IN_Y]),
    .c_vld_i(vld[IN_C]),
    .c_col_i(col[IN_C]),
    .sel_x_o(sel[0]),
    .sel_y_o(sel[1]),
    .c_acc_o(c_ready_o)
  );

  always_comb begin
    unique case (sel[1])
      SEL_X:   y_here = here[IN_X];
      SEL_Y:   y_here = here[IN_Y];
      SEL_C:   y_here = here[IN_C];
      default: y_here = 1'b0;
    endcase
  end

  assign dlv_sel[0] = 1'b0;
  assign dlv_sel[1] = y_here;

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    tor_out_stage #(.MSG_W(MSG_W)) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sel_i  (sel[o]),
      .dlv_i  (dlv_sel[o]),
      .x_msg_i(x_i),
      .y_msg_i(y_i),
      .c_msg_i(c_i),
      .q_o    (q[o]),
      .dlv_o  (dlv_q[o])
    );
  end

  assign x_o   = q[0];
  assign y_o   = q[1];
  assign dlv_o = dlv_q[1];
endmodule

// File: rtl/tor_router_chk.sv
module tor_router_chk #(
  parameter int unsigned X_W   = 2,
  parameter int unsigned Y_W   = 2,
  parameter int unsigned PAY_W = 8,
  parameter int unsigned MY_X  = 1,
  parameter int unsigned MY_Y  = 2,
  localparam int unsigned MSG_W = 1 + X_W + Y_W + PAY_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [MSG_W-1:0] x_i,
  input logic [MSG_W-1:0] y_i,
  input logic [MSG_W-1:0] c_i,
  input logic             c_ready_o,
  input logic [MSG_W-1:0] x_o,
  input logic [MSG_W-1:0] y_o,
  input logic             dlv_o
);
  localparam int unsigned V = MSG_W - 1;

  logic       started;
  logic [1:0] in_cnt, out_cnt;
  logic       x_col;

  assign x_col   = (x_i[V-1 -: X_W] == X_W'(MY_X));
  assign in_cnt  = 2'(x_i[V]) + 2'(y_i[V]) + 2'(c_i[V] && c_ready_o);
  assign out_cnt = 2'(x_o[V]) + 2'(y_o[V]) + 2'(dlv_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started <= 1'b0;
    else         started <= 1'b1;
  end

  a_r3_y_keeps_y: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_i[V] |=> (y_o[V-1:0] == $past(y_i[V-1:0])));

  a_r4_x_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_i[V] && !x_col) |=> (x_o == $past(x_i)));

  a_r6_deflect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_i[V] && x_col && y_i[V]) |=> (x_o == $past(x_i)));

  a_r7_deliver_clears_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_o |-> (!y_o[V] && y_o[V-1 -: X_W] == X_W'(MY_X)
               && y_o[PAY_W +: Y_W] == Y_W'(MY_Y)));

  a_r8_ready_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_ready_o |-> c_i[V]);

  a_r9_idle_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!x_i[V] && !y_i[V] && !c_i[V]) |=> (x_o == '0 && y_o == '0 && !dlv_o));

  a_r10_conserve: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started |-> (out_cnt == $past(in_cnt)));
endmodule

bind tor_router tor_router_chk #(
  .X_W  (X_W),
  .Y_W  (Y_W),
  .PAY_W(PAY_W),
  .MY_X (MY_X),
  .MY_Y (MY_Y)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .x_i      (x_i),
  .y_i      (y_i),
  .c_i      (c_i),
  .c_ready_o(c_ready_o),
  .x_o      (x_o),
  .y_o      (y_o),
  .dlv_o    (dlv_o)
);

// File: tb/tb_tor_router.sv
`timescale 1ns/1ps
module tb_tor_router;
  localparam int unsigned X_W   = 2;
  localparam int unsigned Y_W   = 2;
  localparam int unsigned PAY_W = 8;
  localparam int unsigned MY_X  = 1;
  localparam int unsigned MY_Y  = 2;
  localparam int unsigned MSG_W = 1 + X_W + Y_W + PAY_W;
  localparam int unsigned V     = MSG_W - 1;
  typedef logic [MSG_W-1:0] msg_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  msg_t x_r = '0, y_r = '0, c_r = '0;
  logic c_ready;
  msg_t x_q, y_q;
  logic dlv_q;
  int   n_cmp = 0, n_bad = 0;
  bit   done = 0;

  always #2.5 clk = ~clk;

  tor_router #(.X_W(X_W), .Y_W(Y_W), .PAY_W(PAY_W), .MY_X(MY_X), .MY_Y(MY_Y)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .x_i(x_r), .y_i(y_r), .c_i(c_r),
    .c_ready_o(c_ready), .x_o(x_q), .y_o(y_q), .dlv_o(dlv_q)
  );

  function automatic msg_t mk(bit v, int dx, int dy, int p);
    msg_t m;
    m = '0;
    m[V] = v;
    m[V-1 -: X_W] = X_W'(dx);
    m[PAY_W +: Y_W] = Y_W'(dy);
    m[PAY_W-1:0] = PAY_W'(p);
    return m;
  endfunction

  function automatic int dst_col(msg_t m); return int'(m[V-1 -: X_W]); endfunction
  function automatic int dst_row(msg_t m); return int'(m[PAY_W +: Y_W]); endfunction

  // behavioural reference for one hop
  task automatic model(input msg_t x, input msg_t y, input msg_t c,
                       output msg_t ex, output msg_t ey, output bit ed, output bit er);
    bit x_full = 0, y_full = 0;
    msg_t to_y = '0;
    ex = '0; ey = '0; ed = 0; er = 0;
    if (y[V]) begin y_full = 1; to_y = y; end
    if (x[V]) begin
      if (dst_col(x) == MY_X && !y_full) begin y_full = 1; to_y = x; end
      else begin x_full = 1; ex = x; end
    end
    if (c[V]) begin
      if (dst_col(c) == MY_X) begin
        if (!y_full) begin y_full = 1; to_y = c; er = 1; end
      end else if (!x_full) begin
        x_full = 1; ex = c; er = 1;
      end
    end
    ey = to_y;
    if (y_full && dst_col(to_y) == MY_X && dst_row(to_y) == MY_Y) begin
      ed = 1; ey[V] = 1'b0;
    end
  endtask

  task automatic chk(string tag, logic [MSG_W-1:0] act, logic [MSG_W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic hop(string tag, msg_t x, msg_t y, msg_t c);
    msg_t ex, ey;
    bit ed, er;
    @(negedge clk);
    x_r = x; y_r = y; c_r = c;
    model(x, y, c, ex, ey, ed, er);
    #1;
    chk({tag, " ready"}, MSG_W'(c_ready), MSG_W'(er));
    @(posedge clk);
    #1;
    chk({tag, " x_o"}, x_q, ex);
    chk({tag, " y_o"}, y_q, ey);
    chk({tag, " dlv_o"}, MSG_W'(dlv_q), MSG_W'(ed));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset holds outputs at zero even with traffic offered
    x_r = mk(1, 3, 0, 8'h11);
    y_r = mk(1, 1, 0, 8'h22);
    c_r = mk(1, 0, 0, 8'h33);
    repeat (3) @(posedge clk);
    #1;
    chk("R1 x_o", x_q, '0);
    chk("R1 y_o", y_q, '0);
    chk("R1 dlv_o", MSG_W'(dlv_q), '0);
    @(negedge clk);
    x_r = '0; y_r = '0; c_r = '0;
    rst_ni = 1'b1;

    hop("R4 pass", mk(1, 3, 1, 8'hA1), '0, '0);
    hop("R3 y ring", '0, mk(1, 1, 0, 8'hB2), '0);
    hop("R5 turn", mk(1, 1, 3, 8'hC3), '0, '0);
    hop("R7 deliver from x", mk(1, 1, 2, 8'hD4), '0, '0);
    hop("R7 deliver from y", '0, mk(1, 1, 2, 8'hD5), '0);
    hop("R6 deflect", mk(1, 1, 2, 8'hE6), mk(1, 1, 0, 8'hE7), '0);
    hop("R2 fields kept", mk(1, 2, 3, 8'hFF), mk(1, 1, 1, 8'h00), '0);
    hop("R8 inject x", '0, '0, mk(1, 0, 0, 8'h31));
    hop("R8 inject y", '0, '0, mk(1, 1, 0, 8'h32));
    hop("R8 inject self", '0, '0, mk(1, 1, 2, 8'h33));
    hop("R8 blocked by x", mk(1, 2, 0, 8'h41), '0, mk(1, 0, 1, 8'h42));
    hop("R8 blocked by y", '0, mk(1, 1, 3, 8'h43), mk(1, 1, 1, 8'h44));
    hop("R8 blocked by turn", mk(1, 1, 0, 8'h45), '0, mk(1, 1, 3, 8'h46));
    hop("R8 x free beside y", '0, mk(1, 1, 3, 8'h47), mk(1, 3, 3, 8'h48));
    hop("R8 blocked by deflect", mk(1, 1, 0, 8'h49), mk(1, 1, 1, 8'h4A), mk(1, 2, 2, 8'h4B));
    hop("R9 idle junk", mk(0, 1, 2, 8'h55), mk(0, 1, 2, 8'h66), mk(0, 1, 2, 8'h77));
    hop("R9 empty", '0, '0, '0);

    for (int i = 0; i < 4000; i++) begin
      msg_t rx, ry, rc;
      rx = mk($urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 255));
      ry = mk($urandom_range(0, 1), MY_X, $urandom_range(0, 3), $urandom_range(0, 255));
      rc = mk($urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 255));
      hop("R10 random", rx, ry, rc);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule